// File: doc/BRIEF.md
# HDLC Frame Transmitter with Selectable Line Code

This block turns a stream of payload bytes into a bit-synchronous HDLC frame on a single serial wire. A byte source hands over bytes with a valid/ready handshake and marks the final byte of a frame. The transmitter opens the frame with a flag, sends the payload least-significant bit first, appends a frame check sequence and closes with another flag. A zero is inserted after every run of five ones in the payload and check fields so that no flag can appear inside the frame.

The serial stream advances on a one-cycle tick input. NRZ and NRZI use one tick per bit. FM0, FM1 and Manchester use two ticks per bit, one for each half-bit symbol. Between frames the wire carries a fill of either steady ones or back-to-back flags. A request-to-send output is high for exactly the bits that belong to a frame, so it can enable a line driver directly. If the source stops supplying bytes before the final byte, the frame is aborted with a run of ones.

Top module: `hdlc_tx_top`

## Requirements
- R1: While reset is held and before the first tick, `txOut` is 1, `rts` is 0 and `inReady` is 0.
- R2: With `idleFlags`=0 the wire carries continuous ones between frames. With `idleFlags`=1 it carries repeated flag bytes 0x7E, so every 8-bit window holds six ones and the pattern repeats every 8 bits.
- R3: A frame on the wire is the flag 0x7E, then the payload bytes least-significant bit first, then the check sequence, then the flag 0x7E. Flag bits are never stuffed.
- R4: Inside the payload and check fields, a 0 is inserted after every five consecutive 1 bits, including after the last check bit.
- R5: With `crcSel`=0 the check is 16 bits with generator 0x1021, preset to 0xFFFF at each frame start. Its ones' complement is sent highest-order bit first.
- R6: With `crcSel`=1 the check is 32 bits with generator 0x04C11DB7, preset to all ones. Its ones' complement is sent highest-order bit first.
- R7: `rts` is high for exactly the symbols of the frame's bits, from the first opening-flag bit to the last closing-flag bit (or the last abort bit). It changes only on a tick.
- R8: `lineCode`=0 (NRZ) puts each bit on the wire as is. `lineCode`=1 (NRZI) toggles the wire for a 0 and holds it for a 1.
- R9: `lineCode`=2 (FM0) and `lineCode`=3 (FM1) toggle the wire at the start of every bit. FM0 toggles again mid-bit for a 0, FM1 mid-bit for a 1.
- R10: `lineCode`=4 (Manchester) sends the inverse of the bit in the first half and the bit itself in the second half, so every bit has a mid-bit transition.
- R11: A byte is taken on a clock edge where `inValid` and `inReady` are both high. `inReady` is never high without `inValid`. The byte taken with `inLast`=1 is the final payload byte of the frame.
- R12: If `inValid` is low when the next payload byte is needed, the frame ends with eight unstuffed ones, with no check sequence and no closing flag. The wire then returns to the fill, and no further byte of that frame is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | One-cycle symbol tick |
| lineCode | input | 3 | Line code: 0 NRZ, 1 NRZI, 2 FM0, 3 FM1, 4 Manchester |
| crcSel | input | 1 | 0 selects the 16-bit check, 1 the 32-bit check |
| idleFlags | input | 1 | 0 fills idle time with ones, 1 with flags |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte is offered |
| inLast | input | 1 | Offered byte is the frame's last |
| inReady | output | 1 | Payload byte is taken this cycle |
| txOut | output | 1 | Encoded serial line |
| rts | output | 1 | Request to send, high while frame bits are on the line |

## Verification
The assertions check, on every cycle, the properties that hold locally: that a byte is never accepted without valid, that the stuffing run counter stays within five, that the check register is preset at a frame start, that the FM codes produce a boundary transition, that Manchester produces a mid-bit transition, and that `rts` only falls on a tick. Frame content cannot be seen from any single cycle. Correct stuffing placement, the exact check sequence values for both polynomials, RTS framing over a whole frame, NRZI and FM decoding, idle fill patterns and abort behaviour are shown only by the directed scenarios, which decode the wire and compare it against a bit stream built from the requirements.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    LC_NRZ  = 3'd0,
    LC_NRZI = 3'd1,
    LC_FM0  = 3'd2,
    LC_FM1  = 3'd3,
    LC_MAN  = 3'd4
  } lineCode_e;

  // Kind of 8..32-bit unit the datapath shifts out next
  typedef enum logic [1:0] {
    UK_FILL = 2'd0,   // eight ones, unstuffed
    UK_FLAG = 2'd1,   // 0x7E, unstuffed
    UK_DATA = 2'd2,   // payload byte, stuffed, into CRC
    UK_FCS  = 2'd3    // complemented check, stuffed
  } unitKind_e;

  typedef struct packed {
    logic      load;
    unitKind_e kind;
    logic      inFrame;
    logic      crcInit;
  } txStrobe_t;

  localparam int          FCS_MAX    = 32;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [15:0] POLY_CRC16 = 16'h1021;
  localparam logic [31:0] POLY_CRC32 = 32'h04C1_1DB7;

endpackage

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      unitDone,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      idleFlags,
  output logic      inReady,
  output txStrobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } ctrlState_e;

  ctrlState_e state, stateNxt;
  logic       lastByte;

  always_comb begin
    stateNxt    = state;
    stb         = '0;
    stb.kind    = UK_FILL;
    inReady     = 1'b0;
    if (unitDone) begin
      stb.load = 1'b1;
      case (state)
        ST_IDLE: begin
          if (inValid) begin
            stb.kind    = UK_FLAG;
            stb.inFrame = 1'b1;
            stb.crcInit = 1'b1;
            stateNxt    = ST_OPEN;
          end else begin
            stb.kind = idleFlags ? UK_FLAG : UK_FILL;
          end
        end
        ST_OPEN, ST_DATA: begin
          stb.inFrame = 1'b1;
          if (state == ST_DATA && lastByte) begin
            stb.kind = UK_FCS;
            stateNxt = ST_FCS;
          end else if (inValid) begin
            stb.kind = UK_DATA;
            inReady  = 1'b1;
            stateNxt = ST_DATA;
          end else begin
            stb.kind = UK_FILL;
            stateNxt = ST_ABORT;
          end
        end
        ST_FCS: begin
          stb.kind    = UK_FLAG;
          stb.inFrame = 1'b1;
          stateNxt    = ST_CLOSE;
        end
        default: begin
          stb.kind = idleFlags ? UK_FLAG : UK_FILL;
          stateNxt = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastByte <= 1'b0;
    end else begin
      state <= stateNxt;
      if (inReady) lastByte <= inLast;
    end
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> inValid); // R11

  AST_FCS_THEN_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FCS |=> (state == ST_FCS || state == ST_CLOSE)); // R3

endmodule

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_MAX = 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              take,
  input  logic              crcSel,
  input  logic [BYTE_W-1:0] inData,
  input  txStrobe_t         stb,
  output logic              newBit,
  output logic              newInFrame,
  output logic              unitDone
);

  localparam int CNT_W = $clog2(FCS_MAX + 1);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  logic [FCS_MAX-1:0] sreg, crcReg, crcNext, crcEff, fcsInv, fcsRev, loadVec;
  logic [CNT_W-1:0]   cnt, loadCnt;
  logic [RUN_W-1:0]   onesRun;
  logic               stuffOn, crcOn, inFrameR;
  logic               loadStuff, loadCrcOn;
  logic               stuffNow, endsRun, crcUpd, fb16, fb32;

  assign stuffNow   = stuffOn && (onesRun == RUN_W'(RUN_MAX));
  assign endsRun    = stuffOn && sreg[0] && (onesRun == RUN_W'(RUN_MAX - 1));
  assign newBit     = stuffNow ? 1'b0 : sreg[0];
  assign newInFrame = inFrameR;
  assign unitDone   = take && (stuffNow ? (cnt == '0)
                                        : (cnt == CNT_W'(1) && !endsRun));
  assign crcUpd     = take && !stuffNow && crcOn;

  // Bit-serial check update, data bit in transmission order
  always_comb begin
    crcNext = crcReg;
    fb16    = crcReg[15] ^ sreg[0];
    fb32    = crcReg[FCS_MAX-1] ^ sreg[0];
    if (crcSel)
      crcNext = {crcReg[FCS_MAX-2:0], 1'b0} ^ (fb32 ? POLY_CRC32 : '0);
    else
      crcNext[15:0] = {crcReg[14:0], 1'b0} ^ (fb16 ? POLY_CRC16 : 16'h0);
  end

  assign crcEff = crcUpd ? crcNext : crcReg;
  assign fcsInv = ~crcEff;

  // Reverse so the highest-order check bit leaves the LSB end first
  always_comb begin
    fcsRev = '0;
    for (int i = 0; i < FCS_MAX; i++) begin
      if (crcSel)      fcsRev[i] = fcsInv[FCS_MAX-1-i];
      else if (i < 16) fcsRev[i] = fcsInv[15-i];
    end
  end

  always_comb begin
    loadVec   = '0;
    loadCnt   = CNT_W'(8);
    loadStuff = 1'b0;
    loadCrcOn = 1'b0;
    case (stb.kind)
      UK_FILL: loadVec[7:0] = 8'hFF;
      UK_FLAG: loadVec[7:0] = FLAG_BYTE;
      UK_DATA: begin
        loadVec[BYTE_W-1:0] = inData;
        loadCnt   = CNT_W'(BYTE_W);
        loadStuff = 1'b1;
        loadCrcOn = 1'b1;
      end
      default: begin
        loadVec   = fcsRev;
        loadCnt   = crcSel ? CNT_W'(32) : CNT_W'(16);
        loadStuff = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sreg     <= FCS_MAX'(8'hFF);
      cnt      <= CNT_W'(8);
      onesRun  <= '0;
      stuffOn  <= 1'b0;
      crcOn    <= 1'b0;
      inFrameR <= 1'b0;
      crcReg   <= '1;
    end else begin
      if (take) begin
        if (stuffNow) begin
          onesRun <= '0;
        end else begin
          onesRun <= (stuffOn && sreg[0]) ? onesRun + 1'b1 : '0;
          sreg    <= sreg >> 1;
          cnt     <= cnt - 1'b1;
        end
      end
      if (crcUpd) crcReg <= crcNext;
      if (stb.load) begin
        sreg     <= loadVec;
        cnt      <= loadCnt;
        stuffOn  <= loadStuff;
        crcOn    <= loadCrcOn;
        inFrameR <= stb.inFrame;
        if (stb.crcInit) crcReg <= '1;
      end
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    onesRun <= RUN_W'(RUN_MAX)); // R4

  AST_CRC_PRESET: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && stb.crcInit |=> crcReg == '1); // R5

endmodule

// File: rtl/hdlc_line_enc.sv
module hdlc_line_enc
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitEn,
  input  lineCode_e lineCode,
  input  logic      newBit,
  input  logic      newInFrame,
  output logic      take,
  output logic      txOut,
  output logic      rts
);

  logic      lvl, curBit, needSecond, rtsR, twoSym;
  lineCode_e codeR;

  assign twoSym = (lineCode == LC_FM0) || (lineCode == LC_FM1) || (lineCode == LC_MAN);
  assign take   = bitEn && !needSecond;
  assign txOut  = lvl;
  assign rts    = rtsR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl        <= 1'b1;
      curBit     <= 1'b1;
      needSecond <= 1'b0;
      rtsR       <= 1'b0;
      codeR      <= LC_NRZ;
    end else if (take) begin
      curBit     <= newBit;
      rtsR       <= newInFrame;
      codeR      <= lineCode;
      needSecond <= twoSym;
      case (lineCode)
        LC_NRZI:        lvl <= newBit ? lvl : ~lvl;
        LC_FM0, LC_FM1: lvl <= ~lvl;
        LC_MAN:         lvl <= ~newBit;
        default:        lvl <= newBit;
      endcase
    end else if (bitEn) begin
      needSecond <= 1'b0;
      case (codeR)
        LC_FM0:  if (!curBit) lvl <= ~lvl;
        LC_FM1:  if (curBit)  lvl <= ~lvl;
        LC_MAN:  lvl <= curBit;
        default: lvl <= lvl;
      endcase
    end
  end

  AST_MANCH_MID: assert property (@(posedge clk) disable iff (!rstN)
    bitEn && needSecond && codeR == LC_MAN |=> txOut != $past(txOut)); // R10

  AST_FM_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    take && (lineCode == LC_FM0 || lineCode == LC_FM1) |=> txOut != $past(txOut)); // R9

endmodule

// File: rtl/hdlc_tx_top.sv
module hdlc_tx_top
  import hdlc_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int RUN_MAX = 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [2:0]        lineCode,
  input  logic              crcSel,
  input  logic              idleFlags,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              txOut,
  output logic              rts
);

  txStrobe_t stb;
  logic      unitDone, take, newBit, newInFrame;

  hdlc_tx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .unitDone (unitDone),
    .inValid  (inValid),
    .inLast   (inLast),
    .idleFlags(idleFlags),
    .inReady  (inReady),
    .stb      (stb)
  );

  hdlc_tx_dp #(.BYTE_W(BYTE_W), .RUN_MAX(RUN_MAX)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .take      (take),
    .crcSel    (crcSel),
    .inData    (inData),
    .stb       (stb),
    .newBit    (newBit),
    .newInFrame(newInFrame),
    .unitDone  (unitDone)
  );

  hdlc_line_enc u_enc (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .lineCode  (lineCode_e'(lineCode)),
    .newBit    (newBit),
    .newInFrame(newInFrame),
    .take      (take),
    .txOut     (txOut),
    .rts       (rts)
  );

  AST_RTS_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rts) |-> $past(bitEn)); // R7

endmodule

// File: tb/tb_hdlc_tx_top.sv
`timescale 1ns/1ps
module tb_hdlc_tx_top;

  logic       clk = 1'b0, rstN = 1'b0, bitEn = 1'b0;
  logic [2:0] lineCode = 3'd0;
  logic       crcSel = 1'b0, idleFlags = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0, inLast = 1'b0;
  logic       inReady, txOut, rts;

  always #2.5 clk = ~clk;

  hdlc_tx_top dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .lineCode(lineCode),
    .crcSel(crcSel), .idleFlags(idleFlags), .inData(inData),
    .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .txOut(txOut), .rts(rts)
  );

  int  total = 0, bad = 0, cyc = 0, idx = 0, stopAt = 0;
  bit  sending = 0, takeNext = 0, sampleNext = 0;
  byte unsigned payload[$];
  bit  symV[$], symR[$];

  task automatic check(bit ok, string tag, string detail);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (sampleNext) begin
      symV.push_back(txOut);
      symR.push_back(rts);
    end
    if (takeNext) idx++;
    inValid = sending && (idx < stopAt) && (idx < payload.size());
    inData  = (idx < payload.size()) ? payload[idx] : 8'h00;
    inLast  = (idx == payload.size() - 1);
    bitEn   = (cyc % 2 == 0);
    cyc++;
    #1;
    takeNext   = inReady && inValid;
    sampleNext = bitEn;
  endtask

  function automatic void pushByte(ref bit q[$], input logic [7:0] b);
    for (int k = 0; k < 8; k++) q.push_back(b[k]);
  endfunction

  // Expected line bits from the requirements
  function automatic void buildExp(bit is32, int nSent, bit aborted, ref bit exp[$]);
    bit body[$];
    logic [31:0] c = '1;
    logic fb;
    int run = 0;
    exp.delete();
    pushByte(exp, 8'h7E);
    for (int b = 0; b < nSent; b++)
      for (int k = 0; k < 8; k++) begin
        bit bt = payload[b][k];
        body.push_back(bt);
        if (is32) begin
          fb = c[31] ^ bt;
          c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end else begin
          fb = c[15] ^ bt;
          c[15:0] = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0);
        end
      end
    if (!aborted)
      for (int k = (is32 ? 31 : 15); k >= 0; k--) body.push_back(~c[k]);
    foreach (body[i]) begin
      exp.push_back(body[i]);
      run = body[i] ? run + 1 : 0;
      if (run == 5) begin
        exp.push_back(1'b0);
        run = 0;
      end
    end
    if (aborted) pushByte(exp, 8'hFF);
    else         pushByte(exp, 8'h7E);
  endfunction

  function automatic void decode(int code, ref bit got[$], output int nSym, output int badEdges);
    int f = -1, l = -1;
    bit prev;
    got.delete();
    badEdges = 0;
    foreach (symR[i]) if (symR[i]) begin
      if (f < 0) f = i;
      l = i;
    end
    nSym = 0;
    foreach (symR[i]) if (symR[i]) nSym++;
    if (f < 0) return;
    prev = (f > 0) ? symV[f-1] : 1'b1;
    if (code < 2) begin
      for (int i = f; i <= l; i++) begin
        got.push_back(code == 0 ? symV[i] : (symV[i] == prev));
        prev = symV[i];
      end
    end else begin
      for (int i = f; i + 1 <= l; i += 2) begin
        bit a = symV[i], b = symV[i+1];
        if (code != 4 && a == prev) badEdges++;
        if (code == 2)      got.push_back(a == b);
        else if (code == 3) got.push_back(a != b);
        else begin
          if (a == b) badEdges++;
          got.push_back(b);
        end
        prev = b;
      end
    end
  endfunction

  task automatic runFrame(int code, bit is32, int stop, ref bit got[$],
                          output int nSym, output int badEdges);
    bit seenHigh = 0, done = 0;
    lineCode = 3'(code);
    crcSel   = is32;
    repeat (40) step();
    symV.delete();
    symR.delete();
    idx = 0;
    stopAt = stop;
    sending = 1;
    for (int i = 0; i < 8000 && !done; i++) begin
      step();
      if (symR.size() > 0) begin
        if (symR[$]) seenHigh = 1;
        else if (seenHigh) done = 1;
      end
    end
    repeat (30) step();
    sending = 0;
    decode(code, got, nSym, badEdges);
  endtask

  task automatic compareFrame(string tag, ref bit exp[$], ref bit got[$], input int nSym, input int spb);
    int mm = -1;
    check(got.size() == exp.size(), tag,
          $sformatf("frame bits got %0d want %0d", got.size(), exp.size()));
    foreach (exp[i]) if (mm < 0 && (i >= got.size() || got[i] != exp[i])) mm = i;
    check(mm < 0, tag, $sformatf("first bit mismatch at %0d got %0b want %0b",
          mm, (mm >= 0 && mm < got.size()) ? got[mm] : 1'b0, (mm >= 0) ? exp[mm] : 1'b0));
    check(nSym == exp.size() * spb, "R7",
          $sformatf("rts symbols got %0d want %0d", nSym, exp.size() * spb));
  endtask

  task automatic t_reset();
    check(txOut == 1'b1, "R1", $sformatf("txOut got %0b want 1", txOut));
    check(rts == 1'b0, "R1", $sformatf("rts got %0b want 0", rts));
    check(inReady == 1'b0, "R1", $sformatf("inReady got %0b want 0", inReady));
  endtask

  task automatic t_idleOnes();
    int ones = 0, hi = 0;
    idleFlags = 0; lineCode = 3'd0;
    repeat (30) step();
    symV.delete(); symR.delete();
    repeat (80) step();
    foreach (symV[i]) begin ones += symV[i]; hi += symR[i]; end
    check(ones == symV.size(), "R2", $sformatf("idle ones got %0d want %0d", ones, symV.size()));
    check(hi == 0, "R7", $sformatf("rts during idle got %0d want 0", hi));
  endtask

  task automatic t_idleFlags();
    int ones = 0, diff = 0;
    idleFlags = 1; lineCode = 3'd0;
    repeat (40) step();
    symV.delete(); symR.delete();
    repeat (80) step();
    for (int i = 0; i < 8; i++) ones += symV[i];
    for (int i = 0; i + 8 < symV.size(); i++) if (symV[i] != symV[i+8]) diff++;
    check(ones == 6, "R2", $sformatf("ones per flag window got %0d want 6", ones));
    check(diff == 0, "R2", $sformatf("flag fill period breaks got %0d want 0", diff));
    idleFlags = 0;
  endtask

  task automatic t_nrz16();
    bit exp[$], got[$];
    int nSym, be, run = 0, maxRun = 0;
    logic [7:0] fl = 8'h00;
    payload = '{8'h01, 8'h7E, 8'hFF, 8'hFF};
    runFrame(0, 0, 4, got, nSym, be);
    buildExp(0, 4, 0, exp);
    compareFrame("R5", exp, got, nSym, 1);
    if (got.size() >= 16) begin
      for (int i = 0; i < 8; i++) fl[i] = got[i];
      for (int i = 8; i < got.size() - 8; i++) begin
        run = got[i] ? run + 1 : 0;
        if (run > maxRun) maxRun = run;
      end
    end
    check(fl == 8'h7E, "R3", $sformatf("opening flag got %02h want 7e", fl));
    check(maxRun == 5, "R4", $sformatf("longest ones run in body got %0d want 5", maxRun));
    check(idx == 4, "R11", $sformatf("bytes taken got %0d want 4", idx));
  endtask

  task automatic t_crc32();
    bit exp[$], got[$];
    int nSym, be;
    payload = '{8'hA5, 8'h3C, 8'hFF, 8'hF8, 8'h00};
    runFrame(0, 1, 5, got, nSym, be);
    buildExp(1, 5, 0, exp);
    compareFrame("R6", exp, got, nSym, 1);
  endtask

  task automatic t_single();
    bit exp[$], got[$];
    int nSym, be;
    payload = '{8'h3F};
    runFrame(0, 0, 1, got, nSym, be);
    buildExp(0, 1, 0, exp);
    compareFrame("R11", exp, got, nSym, 1);
    check(idx == 1, "R11", $sformatf("bytes taken got %0d want 1", idx));
  endtask

  task automatic t_code(int code, string tag);
    bit exp[$], got[$];
    int nSym, be;
    payload = '{8'h00, 8'hF7, 8'h1F, 8'h81};
    runFrame(code, 0, 4, got, nSym, be);
    buildExp(0, 4, 0, exp);
    compareFrame(tag, exp, got, nSym, (code < 2) ? 1 : 2);
    check(be == 0, tag, $sformatf("missing transitions got %0d want 0", be));
  endtask

  task automatic t_abort();
    bit exp[$], got[$];
    int nSym, be, ones = 0;
    payload = '{8'h1F, 8'hF0, 8'h55};
    runFrame(0, 0, 2, got, nSym, be);
    buildExp(0, 2, 1, exp);
    compareFrame("R12", exp, got, nSym, 1);
    check(idx == 2, "R12", $sformatf("bytes taken got %0d want 2", idx));
    for (int i = symV.size() - 10; i < symV.size(); i++) ones += symV[i] & ~symR[i];
    check(ones == 10, "R12", $sformatf("idle ones after abort got %0d want 10", ones));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, got timeout want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_idleOnes();
    t_idleFlags();
    t_nrz16();
    t_crc32();
    t_single();
    t_code(1, "R8");
    t_code(2, "R9");
    t_code(3, "R9");
    t_code(4, "R10");
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule